// File: doc/BRIEF.md
# Stuck-at Fault Grader for a Two-Input Multiplexer

This block grades a stream of test vectors against every single stuck-at fault of one fixed gate netlist: a 2-to-1 multiplexer made of an inverter, two AND gates and an OR gate. The netlist computes `y = (~sel & da) | (sel & db)`. The select line is a stem that splits into two branches. The inverted branch feeds the inverter in front of the AND gate that passes `da`. The direct branch feeds the AND gate that passes `db`. For each accepted vector, the block evaluates one fault-free copy of the netlist and sixteen faulty copies side by side. Each faulty copy has exactly one line held at a constant. A fault counts as detected when its copy's output differs from the fault-free output.

Detections accumulate in a sticky bitmap, together with a registered count of detected faults, until software-free use of the clear input starts a new grading run. A one-cycle completion pulse marks the moment every fault in the list has been detected. A test-pattern generator or a bench feeds vectors into the block, reads back the coverage, and compares candidate vector sets.

Top module: `stuckat_grader`

## Requirements
- R1: After a synchronous active-low reset, the bitmap is all zero, the count is zero and the completion pulse is low.
- R2: The vector bits are bit 2 = select, bit 1 = `da`, bit 0 = `db`. Fault index k stands for site k/2 stuck at the value k%2. The sites in order are: select stem 0, inverted select branch 1, direct select branch 2, `da` 3, `db` 4, the `da`-side AND output 5, the `db`-side AND output 6, and the OR output 7.
- R3: An accepted vector sets bit k exactly when the output of the netlist with fault k differs from the fault-free output for that vector.
- R4: A branch fault forces only its own branch. The stem and the other branch keep their fault-free values. Vector 110 therefore detects fault 2 (inverted branch stuck at 0) but not fault 4 (direct branch stuck at 0).
- R5: Detected bits are sticky. A later vector never clears a bit.
- R6: The count equals the number of set bitmap bits. Both change on the clock edge that accepts a vector and become visible in the next cycle.
- R7: The completion pulse is high for one cycle, the cycle in which the count first becomes 16 since the last clear or reset. It stays low while further vectors keep the count at 16.
- R8: Clear empties the bitmap, the count and the pulse one cycle later, and takes priority over a vector offered in the same cycle.
- R9: A cycle without a valid vector or a clear leaves the bitmap and the count unchanged.
- R10: The vector set {001, 011, 110, 111} detects all 16 faults. Applying all eight vectors also reaches 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Start a new grading run (synchronous) |
| vec_valid | input | 1 | `vec` holds a vector to grade this cycle |
| vec | input | 3 | {select, da, db} |
| det_map | output | 16 | Sticky detected bit per fault index |
| det_count | output | 5 | Number of detected faults |
| all_done | output | 1 | One-cycle pulse when coverage first reaches 16 of 16 |

## Verification
Each result is due exactly one cycle after its stimulus: the bitmap, the count and the completion pulse are all registered on the edge that takes the vector or the clear, with no further stage. The bench drives inputs on the falling edge. It advances a behavioural model on the rising edge and compares all three outputs with that model on the following falling edge, which is the first point where the registered values are settled. Directed checks are taken at the same falling edge after the stimulus: the branch-fault distinction, the priority of clear, the idle hold and the single pulse.

// File: rtl/grade_pkg.sv
// Shared constants, types and helpers for the stuck-at grader.
// Assumes the fixed eight-site multiplexer netlist with two faults per site.
package grade_pkg;

    localparam int NUM_SITES  = 8;
    localparam int NUM_FAULTS = 2 * NUM_SITES;
    localparam int CNT_W      = $clog2(NUM_FAULTS + 1);
    localparam int VEC_W      = 3;

    // Fault sites in index order; fault k is site k/2 stuck at k%2.
    typedef enum int {
        SITE_SEL      = 0,
        SITE_SEL_INV  = 1,
        SITE_SEL_DIR  = 2,
        SITE_DA       = 3,
        SITE_DB       = 4,
        SITE_AND_A    = 5,
        SITE_AND_B    = 6,
        SITE_OUT      = 7
    } site_e;

    typedef logic [NUM_FAULTS-1:0] fault_map_t;
    typedef logic [CNT_W-1:0]      fault_cnt_t;

    // Population count of a fault bitmap.
    function automatic fault_cnt_t count_ones(input fault_map_t m);
        fault_cnt_t c;
        c = '0;
        for (int i = 0; i < NUM_FAULTS; i++) begin
            c = c + fault_cnt_t'(m[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/mux_netlist_eval.sv
// Combinational model of the AND-OR multiplexer netlist with one optional
// stuck line. INJECT=0 gives the fault-free copy; otherwise line SITE is
// held at STUCK. A branch fault replaces only that branch's value.
module mux_netlist_eval
    import grade_pkg::*;
#(
    parameter bit INJECT = 1'b0,
    parameter int SITE   = 0,
    parameter bit STUCK  = 1'b0
) (
    input  logic sel,
    input  logic data_a,
    input  logic data_b,
    output logic y
);

    // Return the stuck value on the faulted line, the driven value elsewhere.
    function automatic logic line(input logic driven, input site_e here);
        return (INJECT && (SITE == int'(here))) ? STUCK : driven;
    endfunction

    logic s_stem, s_inv_br, s_dir_br, a_ln, b_ln, g_a, g_b;

    // Evaluate the netlist gate by gate, passing each line through its fault tap.
    always_comb begin
        s_stem   = line(sel, SITE_SEL);
        s_inv_br = line(s_stem, SITE_SEL_INV);
        s_dir_br = line(s_stem, SITE_SEL_DIR);
        a_ln     = line(data_a, SITE_DA);
        b_ln     = line(data_b, SITE_DB);
        g_a      = line(~s_inv_br & a_ln, SITE_AND_A);
        g_b      = line(s_dir_br & b_ln, SITE_AND_B);
        y        = line(g_a | g_b, SITE_OUT);
    end

endmodule

// File: rtl/grade_accum.sv
// Sticky detection store: ORs each accepted hit vector into the bitmap,
// keeps the registered count and raises the completion pulse.
// Assumes hits are valid only while hit_valid is high; clear wins.
module grade_accum
    import grade_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       hit_valid,
    input  fault_map_t hits,
    output fault_map_t det_map,
    output fault_cnt_t det_count,
    output logic       all_done
);

    localparam fault_cnt_t FULL = fault_cnt_t'(NUM_FAULTS);

    fault_map_t next_map;
    fault_cnt_t next_count;

    // Merge new detections and count them ahead of the register.
    always_comb begin
        next_map   = det_map | hits;
        next_count = count_ones(next_map);
    end

    // Bitmap and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            det_map   <= '0;
            det_count <= '0;
        end else if (hit_valid) begin
            det_map   <= next_map;
            det_count <= next_count;
        end
    end

    // Completion pulse on the first arrival at full coverage.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            all_done <= 1'b0;
        end else begin
            all_done <= hit_valid && (next_count == FULL) && (det_count != FULL);
        end
    end

endmodule

// File: rtl/stuckat_grader.sv
// Top of the stuck-at grader: one fault-free netlist copy, one faulty copy
// per fault index, an XOR compare and the sticky store.
// Assumes vec = {select, da, db}; all inputs synchronous to clk.
module stuckat_grader
    import grade_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  vec_valid,
    input  logic [VEC_W-1:0]      vec,
    output logic [NUM_FAULTS-1:0] det_map,
    output logic [CNT_W-1:0]      det_count,
    output logic                  all_done
);

    logic       golden_y;
    fault_map_t faulty_y;
    fault_map_t hits;

    mux_netlist_eval #(.INJECT(1'b0), .SITE(0), .STUCK(1'b0)) u_golden (
        .sel    (vec[2]),
        .data_a (vec[1]),
        .data_b (vec[0]),
        .y      (golden_y)
    );

    for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_fault
        mux_netlist_eval #(.INJECT(1'b1), .SITE(g / 2), .STUCK(bit'(g % 2))) u_faulty (
            .sel    (vec[2]),
            .data_a (vec[1]),
            .data_b (vec[0]),
            .y      (faulty_y[g])
        );
    end

    // A fault is hit when its copy disagrees with the fault-free output.
    always_comb begin
        hits = faulty_y ^ {NUM_FAULTS{golden_y}};
    end

    grade_accum u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .hit_valid (vec_valid),
        .hits      (hits),
        .det_map   (det_map),
        .det_count (det_count),
        .all_done  (all_done)
    );

endmodule

// File: rtl/grade_checker.sv
// Assertion checker for stuckat_grader, attached by bind below.
// Relates the registered outputs to each other and to the inputs over time.
module grade_checker
    import grade_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  clr,
    input logic                  vec_valid,
    input logic [NUM_FAULTS-1:0] det_map,
    input logic [CNT_W-1:0]      det_count,
    input logic                  all_done
);

    // R5: no detected bit drops without a clear.
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((det_map & $past(det_map)) == $past(det_map)));

    // R6: count agrees with the bitmap.
    p_count_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        det_count == CNT_W'($countones(det_map)));

    // R8: clear empties everything one cycle later.
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (det_map == '0 && det_count == '0 && !all_done));

    // R9: idle cycles hold the store.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_valid && !clr) |=> ($stable(det_map) && $stable(det_count) && !all_done));

    // R7: pulse only on arrival at full coverage.
    p_done_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        all_done |-> (det_count == CNT_W'(NUM_FAULTS) && $past(det_count) != CNT_W'(NUM_FAULTS)));

    // R7: pulse lasts one cycle.
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        all_done |=> !all_done);

endmodule

bind stuckat_grader grade_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .vec_valid (vec_valid),
    .det_map   (det_map),
    .det_count (det_count),
    .all_done  (all_done)
);

// File: tb/stuckat_grader_tb.sv
// Bench for stuckat_grader: behavioural model advanced on the rising edge,
// compared on every falling edge, plus directed checks per requirement.
module stuckat_grader_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        vec_valid = 1'b0;
    logic [2:0]  vec = 3'b000;
    logic [15:0] det_map;
    logic [4:0]  det_count;
    logic        all_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    stuckat_grader u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .vec_valid (vec_valid),
        .vec       (vec),
        .det_map   (det_map),
        .det_count (det_count),
        .all_done  (all_done)
    );

    // Output of the multiplexer for inputs x,a,b with fault f (-1 = none).
    function automatic bit mux_out(bit x, bit a, bit b, int f);
        int site;
        bit v, xs, xi, xd, aa, bb, ga, gb, y;
        site = (f < 0) ? -1 : f / 2;
        v    = (f < 0) ? 1'b0 : bit'(f % 2);
        xs = (site == 0) ? v : x;
        xi = (site == 1) ? v : xs;
        xd = (site == 2) ? v : xs;
        aa = (site == 3) ? v : a;
        bb = (site == 4) ? v : b;
        ga = (site == 5) ? v : (!xi && aa);
        gb = (site == 6) ? v : (xd && bb);
        y  = (site == 7) ? v : (ga || gb);
        return y;
    endfunction

    function automatic logic [15:0] hits_of(logic [2:0] v);
        logic [15:0] h;
        for (int f = 0; f < 16; f++) begin
            h[f] = mux_out(v[2], v[1], v[0], f) != mux_out(v[2], v[1], v[0], -1);
        end
        return h;
    endfunction

    logic [15:0] m_det = '0;
    int          m_cnt = 0;
    bit          m_done = 0;

    // Reference model, one update per rising edge.
    always @(posedge clk) begin
        if (!rst_n || clr) begin
            m_det  <= '0;
            m_cnt  <= 0;
            m_done <= 0;
        end else if (vec_valid) begin
            m_det  <= m_det | hits_of(vec);
            m_cnt  <= $countones(m_det | hits_of(vec));
            m_done <= ($countones(m_det | hits_of(vec)) == 16) && (m_cnt != 16);
        end else begin
            m_done <= 0;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Continuous comparison against the model (R3, R6, R7).
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R3 bitmap vs model", int'(det_map), int'(m_det));
            chk("R6 count vs model", int'(det_count), m_cnt);
            chk("R7 done vs model", int'(all_done), int'(m_done));
        end
    end

    // One cycle of stimulus, ending on the next falling edge.
    task automatic step(bit v_ok, logic [2:0] v, bit c);
        vec_valid = v_ok;
        vec       = v;
        clr       = c;
        @(negedge clk);
        vec_valid = 0;
        clr       = 0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 bitmap after reset", int'(det_map), 0);
        chk("R1 count after reset", int'(det_count), 0);
        chk("R1 done after reset", int'(all_done), 0);

        step(1, 3'b110, 0);
        chk("R4 inverted branch stuck-0 detected", int'(det_map[2]), 1);
        chk("R4 direct branch stuck-0 not detected", int'(det_map[4]), 0);
        chk("R2 bitmap for vector 110", int'(det_map), 16'hAA05);
        chk("R6 count after one vector", int'(det_count), 6);

        step(0, 3'b001, 0);
        step(0, 3'b111, 0);
        step(0, 3'b011, 0);
        chk("R9 bitmap held while idle", int'(det_map), 16'hAA05);
        chk("R9 count held while idle", int'(det_count), 6);

        step(1, 3'b001, 1);
        chk("R8 clear beats vector bitmap", int'(det_map), 0);
        chk("R8 clear beats vector count", int'(det_count), 0);

        step(1, 3'b001, 0);
        chk("R7 no pulse before full", int'(all_done), 0);
        step(1, 3'b011, 0);
        step(1, 3'b110, 0);
        step(1, 3'b111, 0);
        chk("R10 four-vector set count", int'(det_count), 16);
        chk("R10 four-vector set bitmap", int'(det_map), 16'hFFFF);
        chk("R7 pulse on reaching full", int'(all_done), 1);
        step(0, 3'b000, 0);
        chk("R7 pulse lasts one cycle", int'(all_done), 0);
        step(1, 3'b111, 0);
        chk("R7 no second pulse at full", int'(all_done), 0);
        chk("R5 bitmap stays full", int'(det_map), 16'hFFFF);

        step(0, 3'b000, 1);
        chk("R8 clear empties bitmap", int'(det_map), 0);
        for (int v = 0; v < 8; v++) begin
            step(1, 3'(v), 0);
            step(0, 3'b000, 0);
        end
        chk("R10 exhaustive set count", int'(det_count), 16);
        chk("R5 exhaustive set bitmap", int'(det_map), 16'hFFFF);

        finish_run();
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R10 watchdog actual=timeout expected=finish");
            finish_run();
        end
    end

endmodule